// File: doc/BRIEF.md
# FIFO Bridge Register Bank with Occupancy Interrupts

This block is the processor-facing register bank of a streaming bridge that has two external FIFOs: a transmit FIFO that software fills and a receive FIFO that software drains. It decodes a simple word-addressed bus with read and write strobes and byte enables. It holds the control bits that keep each FIFO in reset and that select the bridge endpoint. It stores one programmable occupancy threshold for each FIFO. Software can push a single 32-bit word into the transmit FIFO or pop a single word from the receive FIFO with one bus access.

Three interrupt sources are compared or watched every cycle: the receive FIFO holding more words than its threshold, the transmit FIFO holding fewer words than its threshold, and the transmit FIFO being full. A rising edge on any source sets a sticky status bit. Software clears a status bit by writing a one to it. The interrupt line is driven when an enabled status bit is set and the global enable is on.

Top module: `fifo_regbank`

Word addresses: 0 control, 1 thresholds, 2 status, 3 transmit data, 4 receive data, 5 interrupt enable, 6 interrupt status, 7 global enable.

## Requirements
- R1: After reset every register reads zero, `irq`, `tx_fifo_rst`, `rx_fifo_rst` are low and `ep_sel` is 0.
- R2: In the control register, bit 0 drives `tx_fifo_rst`, bit 1 drives `rx_fifo_rst` and bits 5:4 drive `ep_sel`. Each is held until rewritten, reads back as written, and every other bit reads zero.
- R3: In the threshold register, bits [TX_THR_W-1:0] hold the transmit threshold and bits [16+RX_THR_W-1:16] hold the receive threshold. All other bits read zero.
- R4: The status register reads as follows: [12:0] the transmit count, 13 `tx_full`, 14 transmit-low flag (count < transmit threshold), 15 receive-high flag (count > receive threshold), [28:16] the receive count, 29 `rx_empty`.
- R5: A write to the transmit data address pulses `tx_push` for one cycle with `tx_wdata` equal to the written word. The write is dropped when `tx_full` is high.
- R6: A read of the receive data address pulses `rx_pop` once and returns `rx_rdata`. When `rx_empty` is high it returns zero and does not pop.
- R7: Interrupt status bit 0 (receive-high), bit 1 (transmit-low) and bit 2 (`tx_full`) is set on the rising edge of its source. It stays set after the source falls.
- R8: Writing the interrupt status address clears each bit written as one. A rising edge in the same cycle wins over the clear.
- R9: `irq` is high exactly when some bit is set in both the interrupt status and the enable register bits [2:0], and bit 31 of the global enable register is set.
- R10: On a write, only bytes whose byte-enable bit is high are changed.
- R11: Read data and `bus_rvalid` appear in the cycle after the read strobe. `bus_rvalid` is high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_wdata | output | 32 | Word pushed to the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO full |
| tx_count | input | TX_CNT_W | Transmit FIFO word count |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_rdata | input | 32 | Head word of the receive FIFO |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_count | input | RX_CNT_W | Receive FIFO word count |
| tx_fifo_rst | output | 1 | Hold the transmit FIFO in reset |
| rx_fifo_rst | output | 1 | Hold the receive FIFO in reset |
| ep_sel | output | 2 | Endpoint select |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a rising source edge that lands in the same cycle as a software clear of that bit. The bench gets there by changing the receive count at the very falling edge where it also drives the interrupt-status write, so both take effect at one rising edge. Stickiness is checked by letting a source fall and rise again around the clears. The count inputs are stepped across each threshold in both directions, so each comparison is seen on both sides.

// File: rtl/fifo_regbank_pkg.sv
// Package: shared address map, widths and the byte-enable merge helper
// for the FIFO bridge register bank. Assumes a 32-bit data bus.
package fifo_regbank_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int N_IRQ    = 3;
    localparam int N_CFG    = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_THRESH = 3'd1,
        RA_STATUS = 3'd2,
        RA_TXDATA = 3'd3,
        RA_RXDATA = 3'd4,
        RA_IER    = 3'd5,
        RA_ISR    = 3'd6,
        RA_GIE    = 3'd7
    } reg_addr_e;

    // Interrupt source positions (fixed, software decodes them)
    localparam int IRQ_RX_HIGH = 0;
    localparam int IRQ_TX_LOW  = 1;
    localparam int IRQ_TX_FULL = 2;

    // Merge new data into an old word, one byte per enable bit
    function automatic logic [DATA_W-1:0] be_merge(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [DATA_W/8-1:0] be
    );
        logic [DATA_W-1:0] res;
        res = old_w;
        for (int b = 0; b < DATA_W/8; b++) begin
            if (be[b]) res[b*8 +: 8] = new_w[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/regbank_cfg.sv
// Module: regbank_cfg
// Holds the software-writable configuration words (control, thresholds,
// interrupt enable, global enable). Each word keeps only its defined bits
// through a per-register mask; writes honour byte enables.
// Assumes the strobe is a single-cycle pulse already decoded as a write.
module regbank_cfg
    import fifo_regbank_pkg::*;
#(
    parameter int TX_THR_W = 11,
    parameter int RX_THR_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     ctrl_word,
    output logic [DATA_W-1:0]     thr_word,
    output logic [DATA_W-1:0]     ier_word,
    output logic [DATA_W-1:0]     gie_word
);

    localparam logic [DATA_W-1:0] TX_THR_MASK = DATA_W'((64'd1 << TX_THR_W) - 64'd1);
    localparam logic [DATA_W-1:0] RX_THR_MASK = DATA_W'(((64'd1 << RX_THR_W) - 64'd1) << 16);

    // Address and writable-bit mask of configuration slot i
    function automatic logic [ADDR_W-1:0] slot_addr(input int i);
        case (i)
            0:       return RA_CTRL;
            1:       return RA_THRESH;
            2:       return RA_IER;
            default: return RA_GIE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] slot_mask(input int i);
        case (i)
            0:       return 32'h0000_0033;
            1:       return TX_THR_MASK | RX_THR_MASK;
            2:       return DATA_W'((1 << N_IRQ) - 1);
            default: return 32'h8000_0000;
        endcase
    endfunction

    logic [DATA_W-1:0] slot_q [N_CFG];

    for (genvar i = 0; i < N_CFG; i++) begin : g_slot
        // Update one configuration word on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (wr_en && wr_addr == slot_addr(i)) begin
                slot_q[i] <= be_merge(slot_q[i], wr_data, wr_be) & slot_mask(i);
            end
        end
    end

    assign ctrl_word = slot_q[0];
    assign thr_word  = slot_q[1];
    assign ier_word  = slot_q[2];
    assign gie_word  = slot_q[3];

endmodule

// File: rtl/regbank_irq.sv
// Module: regbank_irq
// Sticky interrupt status with rising-edge capture, write-one-to-clear,
// per-source enable and a global gate. A rise in the same cycle as a clear
// keeps the bit set. Assumes sources are synchronous to clk.
module regbank_irq
    import fifo_regbank_pkg::*;
#(
    parameter int N_SRC = N_IRQ
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic             clr_en,
    input  logic [N_SRC-1:0] clr_bits,
    input  logic [N_SRC-1:0] enable,
    input  logic             global_en,
    output logic [N_SRC-1:0] status,
    output logic             irq
);

    logic [N_SRC-1:0] src_q;
    logic [N_SRC-1:0] rise;

    // Remember last source level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    assign rise = src & ~src_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        // Sticky status bit: set by rise, cleared by write-one, set wins
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i] <= 1'b0;
            end else if (rise[i]) begin
                status[i] <= 1'b1;
            end else if (clr_en && clr_bits[i]) begin
                status[i] <= 1'b0;
            end
        end
    end

    assign irq = global_en && |(status & enable);

endmodule

// File: rtl/regbank_rd.sv
// Module: regbank_rd
// Registered read-back path: selects one word by address on a read strobe
// and presents it with a one-cycle valid in the next cycle. The receive
// data word is zero when the receive FIFO is empty.
module regbank_rd
    import fifo_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic [DATA_W-1:0] thr_word,
    input  logic [DATA_W-1:0] status_word,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_empty,
    input  logic [DATA_W-1:0] ier_word,
    input  logic [DATA_W-1:0] isr_word,
    input  logic [DATA_W-1:0] gie_word,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic [DATA_W-1:0] sel_word;

    // Choose the word addressed by the current read
    always_comb begin
        case (reg_addr_e'(rd_addr))
            RA_CTRL:   sel_word = ctrl_word;
            RA_THRESH: sel_word = thr_word;
            RA_STATUS: sel_word = status_word;
            RA_RXDATA: sel_word = rx_empty ? '0 : rx_word;
            RA_IER:    sel_word = ier_word;
            RA_ISR:    sel_word = isr_word;
            RA_GIE:    sel_word = gie_word;
            default:   sel_word = '0;
        endcase
    end

    // Register read data and its valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= sel_word;
        end
    end

endmodule

// File: rtl/fifo_regbank.sv
// Module: fifo_regbank (top)
// Register bank between a word-addressed processor bus and two external
// FIFOs. Decodes accesses, drives push/pop strobes, compares FIFO counts
// with programmable thresholds and raises a gated interrupt.
// Assumes TX_CNT_W and RX_CNT_W <= 13 and thresholds <= 16 bits.
module fifo_regbank
    import fifo_regbank_pkg::*;
#(
    parameter int TX_THR_W = 11,
    parameter int RX_THR_W = 11,
    parameter int TX_CNT_W = 12,
    parameter int RX_CNT_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [2:0]          bus_addr,
    input  logic [3:0]          bus_be,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    output logic                tx_push,
    output logic [31:0]         tx_wdata,
    input  logic                tx_full,
    input  logic [TX_CNT_W-1:0] tx_count,
    output logic                rx_pop,
    input  logic [31:0]         rx_rdata,
    input  logic                rx_empty,
    input  logic [RX_CNT_W-1:0] rx_count,
    output logic                tx_fifo_rst,
    output logic                rx_fifo_rst,
    output logic [1:0]          ep_sel,
    output logic                irq
);

    localparam int CNT_FIELD_W = 13;

    logic              wr_en, rd_en;
    logic [DATA_W-1:0] ctrl_word, thr_word, ier_word, gie_word;
    logic [DATA_W-1:0] status_word, isr_word;
    logic [TX_THR_W-1:0] tx_thr;
    logic [RX_THR_W-1:0] rx_thr;
    logic              tx_low, rx_high;
    logic [N_IRQ-1:0]  src, isr_q, ier_q;
    logic              gie_q;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    regbank_cfg #(
        .TX_THR_W (TX_THR_W),
        .RX_THR_W (RX_THR_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (bus_addr),
        .wr_be     (bus_be),
        .wr_data   (bus_wdata),
        .ctrl_word (ctrl_word),
        .thr_word  (thr_word),
        .ier_word  (ier_word),
        .gie_word  (gie_word)
    );

    assign tx_fifo_rst = ctrl_word[0];
    assign rx_fifo_rst = ctrl_word[1];
    assign ep_sel      = ctrl_word[5:4];
    assign tx_thr      = thr_word[TX_THR_W-1:0];
    assign rx_thr      = thr_word[16 +: RX_THR_W];
    assign ier_q       = ier_word[N_IRQ-1:0];
    assign gie_q       = gie_word[31];

    // Occupancy comparisons against the programmed thresholds
    assign tx_low  = 32'(tx_count) < 32'(tx_thr);
    assign rx_high = 32'(rx_count) > 32'(rx_thr);

    // Single-word data ports into and out of the external FIFOs
    assign tx_push  = wr_en && bus_addr == RA_TXDATA && !tx_full;
    assign tx_wdata = bus_wdata;
    assign rx_pop   = rd_en && bus_addr == RA_RXDATA && !rx_empty;

    always_comb begin
        src = '0;
        src[IRQ_RX_HIGH] = rx_high;
        src[IRQ_TX_LOW]  = tx_low;
        src[IRQ_TX_FULL] = tx_full;
    end

    regbank_irq #(
        .N_SRC (N_IRQ)
    ) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src),
        .clr_en    (wr_en && bus_addr == RA_ISR),
        .clr_bits  (bus_wdata[N_IRQ-1:0]),
        .enable    (ier_q),
        .global_en (gie_q),
        .status    (isr_q),
        .irq       (irq)
    );

    // Assemble the status word from counts and flags
    always_comb begin
        status_word = '0;
        status_word[CNT_FIELD_W-1:0]  = CNT_FIELD_W'(tx_count);
        status_word[13]               = tx_full;
        status_word[14]               = tx_low;
        status_word[15]               = rx_high;
        status_word[16 +: CNT_FIELD_W] = CNT_FIELD_W'(rx_count);
        status_word[29]               = rx_empty;
    end

    assign isr_word = DATA_W'(isr_q);

    regbank_rd rd_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .rd_addr     (bus_addr),
        .ctrl_word   (ctrl_word),
        .thr_word    (thr_word),
        .status_word (status_word),
        .rx_word     (rx_rdata),
        .rx_empty    (rx_empty),
        .ier_word    (ier_word),
        .isr_word    (isr_word),
        .gie_word    (gie_word),
        .rdata       (bus_rdata),
        .rvalid      (bus_rvalid)
    );

endmodule

// File: rtl/fifo_regbank_chk.sv
// Module: fifo_regbank_chk
// Property checker for fifo_regbank, attached by bind. Observes bus,
// FIFO strobes and the interrupt status held inside the top.
module fifo_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        bus_rvalid,
    input logic        tx_push,
    input logic        tx_full,
    input logic        rx_pop,
    input logic        rx_empty,
    input logic        tx_fifo_rst,
    input logic        irq,
    input logic [2:0]  src,
    input logic [2:0]  isr_q,
    input logic [2:0]  ier_q,
    input logic        gie_q
);

    logic isr_wr;
    assign isr_wr = bus_sel && bus_wr && bus_addr == 3'd6;

    assert_push_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !tx_full);

    assert_pop_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> !rx_empty);

    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 3'd4 && rx_empty) |=> bus_rdata == 32'd0);

    assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    assert_rvalid_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

    assert_ctrl_txrst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 3'd0 && bus_be[0]) |=> tx_fifo_rst == $past(bus_wdata[0]));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie_q && (isr_q & ier_q) != 3'd0));

    for (genvar i = 0; i < 3; i++) begin : g_bit
        assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (isr_q[i] && !(isr_wr && bus_wdata[i])) |=> isr_q[i]);

        assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (isr_wr && bus_wdata[i] && !src[i]) |=> !isr_q[i]);
    end

endmodule

bind fifo_regbank fifo_regbank_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .tx_push     (tx_push),
    .tx_full     (tx_full),
    .rx_pop      (rx_pop),
    .rx_empty    (rx_empty),
    .tx_fifo_rst (tx_fifo_rst),
    .irq         (irq),
    .src         (src),
    .isr_q       (isr_q),
    .ier_q       (ier_q),
    .gie_q       (gie_q)
);

// File: tb/fifo_regbank_tb_top.sv
// Directed bench for fifo_regbank: one task per scenario, each checking
// its own results at falling clock edges.
module fifo_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        tx_push, rx_pop;
    logic [31:0] tx_wdata;
    logic        tx_full = 1'b0;
    logic [11:0] tx_count = 12'd20;
    logic [31:0] rx_rdata = 32'h1234_5678;
    logic        rx_empty = 1'b1;
    logic [11:0] rx_count = 12'd0;
    logic        tx_fifo_rst, rx_fifo_rst, irq;
    logic [1:0]  ep_sel;

    int errors = 0, checks = 0;
    int pushes = 0, pops = 0;
    logic [31:0] last_push;
    logic done = 1'b0;

    always #10 clk = ~clk;

    fifo_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full),
        .tx_count(tx_count), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_empty(rx_empty), .rx_count(rx_count),
        .tx_fifo_rst(tx_fifo_rst), .rx_fifo_rst(rx_fifo_rst),
        .ep_sel(ep_sel), .irq(irq)
    );

    // Count FIFO strobes seen at clock edges
    always @(posedge clk) begin
        if (tx_push) begin pushes++; last_push = tx_wdata; end
        if (rx_pop) pops++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        check({req, " R11 rvalid"}, 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic test_reset();
        logic [31:0] d;
        check("R1 irq", 32'(irq), 0);
        check("R1 resets", {29'd0, ep_sel, tx_fifo_rst | rx_fifo_rst}, 0);
        for (int a = 0; a < 8; a++) begin
            if (a == 2 || a == 3 || a == 4) continue;
            bus_read(3'(a), d, "R1");
            check("R1 reg zero", d, 0);
        end
    endtask

    task automatic test_ctrl();
        logic [31:0] d;
        bus_write(3'd0, 32'hFFFF_FF31, 4'hF);
        check("R2 tx_rst", 32'(tx_fifo_rst), 1);
        check("R2 rx_rst", 32'(rx_fifo_rst), 0);
        check("R2 ep_sel", 32'(ep_sel), 3);
        bus_read(3'd0, d, "R2");
        check("R2 readback", d, 32'h31);
        bus_write(3'd0, 32'h0000_0002, 4'hF);
        check("R2 release tx", {30'd0, tx_fifo_rst, rx_fifo_rst}, 32'd1);
        bus_write(3'd0, 32'h0, 4'hF);
        check("R2 release rx", 32'(rx_fifo_rst), 0);
    endtask

    task automatic test_byte_en();
        logic [31:0] d;
        bus_write(3'd0, 32'h12, 4'h0);
        bus_read(3'd0, d, "R10");
        check("R10 no-byte write ignored", d, 0);
        bus_write(3'd1, 32'hFFFF_FFFF, 4'b0011);
        bus_read(3'd1, d, "R3");
        check("R3 R10 tx threshold low bytes", d, 32'h0000_07FF);
        bus_write(3'd1, 32'hFFFF_FFFF, 4'b1100);
        bus_read(3'd1, d, "R3");
        check("R3 R10 rx threshold high bytes", d, 32'h07FF_07FF);
        bus_write(3'd5, 32'hFFFF_FFFF, 4'hF);
        bus_read(3'd5, d, "R9");
        check("R9 enable width", d, 32'h7);
        bus_write(3'd5, 32'h0, 4'hF);
        bus_write(3'd7, 32'hFFFF_FFFF, 4'hF);
        bus_read(3'd7, d, "R9");
        check("R9 global bit", d, 32'h8000_0000);
        bus_write(3'd7, 32'h0, 4'hF);
    endtask

    task automatic test_status_irq();
        logic [31:0] d;
        bus_write(3'd1, 32'h0004_0008, 4'hF);   // tx thr 8, rx thr 4
        bus_write(3'd6, 32'h7, 4'hF);
        bus_read(3'd6, d, "R8");
        check("R8 clear all", d, 0);
        @(negedge clk); rx_count = 12'd5;
        @(negedge clk);
        bus_read(3'd6, d, "R7");
        check("R7 rx high latched", d, 32'h1);
        tx_count = 12'd3;
        @(negedge clk); tx_full = 1'b1;
        @(negedge clk); tx_full = 1'b0;
        bus_read(3'd2, d, "R4");
        check("R4 status word", d, 32'h2005_C003);
        bus_read(3'd6, d, "R7");
        check("R7 all three latched", d, 32'h7);
        bus_write(3'd6, 32'h1, 4'hF);
        bus_read(3'd6, d, "R8");
        check("R8 write-one clear bit0", d, 32'h6);
        tx_count = 12'd20; rx_count = 12'd0;
        @(negedge clk);
        bus_read(3'd6, d, "R7");
        check("R7 sticky after source fall", d, 32'h6);
        // rise and clear in the same cycle: set wins
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h7; bus_be = 4'hF;
        rx_count = 12'd6;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(3'd6, d, "R8");
        check("R8 rise wins over clear", d, 32'h1);
        bus_write(3'd5, 32'h7, 4'hF);
        check("R9 no global enable", 32'(irq), 0);
        bus_write(3'd7, 32'h8000_0000, 4'hF);
        check("R9 irq asserted", 32'(irq), 1);
        bus_write(3'd5, 32'h6, 4'hF);
        check("R9 source masked", 32'(irq), 0);
        bus_write(3'd5, 32'h7, 4'hF);
        bus_write(3'd6, 32'h1, 4'hF);
        check("R9 irq after clear", 32'(irq), 0);
    endtask

    task automatic test_data_ports();
        logic [31:0] d;
        int p0;
        p0 = pushes;
        bus_write(3'd3, 32'hCAFE_BABE, 4'hF);
        check("R5 one push", 32'(pushes - p0), 1);
        check("R5 pushed word", last_push, 32'hCAFE_BABE);
        tx_full = 1'b1;
        bus_write(3'd3, 32'h0BAD_0BAD, 4'hF);
        check("R5 dropped when full", 32'(pushes - p0), 1);
        tx_full = 1'b0;
        p0 = pops;
        rx_empty = 1'b0;
        @(negedge clk);
        check("R11 rvalid idle", 32'(bus_rvalid), 0);
        bus_read(3'd4, d, "R6");
        check("R6 read word", d, 32'h1234_5678);
        check("R6 one pop", 32'(pops - p0), 1);
        rx_empty = 1'b1;
        bus_read(3'd4, d, "R6");
        check("R6 empty reads zero", d, 0);
        check("R6 no pop when empty", 32'(pops - p0), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_ctrl();
        test_byte_en();
        test_status_irq();
        test_data_ports();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule